// File: doc/BRIEF.md
# Configurable DRAM Address Decoder

This block turns a flat byte address into the chip-select, row, bank and column coordinates that a DRAM controller needs. All field widths are set at run time through configuration inputs: column, bank and row bit counts, a one-or-two chip-select choice, an interface width code and a field-order code. The same configuration also gives the memory size, which the block reports both in bytes and as a base-2 exponent. Any address at or beyond that size raises an out-of-range flag.

The byte-lane bits below the interface width are removed first. The column, bank, row and chip fields are then taken from the remaining bits, in the order that the order code selects. The chip bit can sit above the row field or between the bank and row fields. ECC lanes add no addressable bytes. A row count that cannot be valid is replaced by a fixed default. The decode is combinational. A parameter chooses whether an output register stage with a clock enable follows it.

Top module: `dram_addr_map`

## Requirements
- R1: The low byte-lane bits of the address are discarded before the column field is taken. Width codes: 0 = 8-bit (0 lane bits), 1 = 16-bit (1), 2 = 32-bit (2), 3 = 16-bit with ECC (1), 4 = 32-bit with ECC (2), codes 5..7 behave as 8-bit.
- R2: With order code 0 or 1, the fields are laid out from the least significant end above the lane bits as column, bank, row, chip. The chip bit sits above the row field.
- R3: With order code 2 or 3, the fields are laid out from the least significant end above the lane bits as column, bank, chip, row. The chip bit sits between the bank and row fields.
- R4: When the two-chip-select input is 0, the chip output is 0 and no address bit is used for it. The row field then starts directly above the bank field under either order code.
- R5: The capacity exponent equals row + bank + column + lane bits + (1 if two chip selects). The capacity in bytes is 2 raised to that exponent. It saturates to all ones when the exponent exceeds ADDR_W.
- R6: ECC width codes 3 and 4 give the same capacity and the same decode as codes 1 and 2. ECC bits add no capacity.
- R7: A row count above 31 is replaced by DEFAULT_ROW (default 14), both in the decode and in the capacity.
- R8: The out-of-range flag is 1 exactly when the address is at or above the capacity. It is never 1 when the capacity is 2^ADDR_W or more.
- R9: With REG_OUT=1, every output reflects the inputs of the previous rising edge at which the enable was 1. While the enable is 0, every output holds.
- R10: While reset is active, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Output register clock enable |
| addr_i | input | ADDR_W | Linear byte address |
| cfg_col_bits_i | input | 4 | Column bit count |
| cfg_bank_bits_i | input | 3 | Bank bit count |
| cfg_row_bits_i | input | 6 | Row bit count (above 31 means invalid) |
| cfg_two_cs_i | input | 1 | 1 = two chip selects, 0 = one |
| cfg_width_i | input | 3 | Interface width code |
| cfg_order_i | input | 2 | Field order code |
| chip_o | output | 1 | Decoded chip select |
| row_o | output | ROW_W | Decoded row |
| bank_o | output | BANK_W | Decoded bank |
| col_o | output | COL_W | Decoded column |
| cap_o | output | ADDR_W+1 | Capacity in bytes (saturating) |
| cap_log2_o | output | 7 | Capacity exponent |
| oor_o | output | 1 | Address at or above capacity |

## Verification
The bench decodes the same address under both order codes with two chip selects. A design that places the chip bit wrongly would give a swapped chip value and a row shifted by one bit. Addresses one below and exactly at the capacity are applied. An off-by-one comparison would flag the last valid byte or would miss the first invalid one. Configurations whose capacity is exactly 2^32, or far above it, catch a flag that wraps or a capacity output that truncates. Invalid row counts, ECC width codes and reserved width codes are also applied. A design that used the raw row count, or that counted ECC lanes, would report a different exponent.

// File: rtl/dram_map_pkg.sv
package dram_map_pkg;
  localparam int COLCNT_W  = 4;
  localparam int BANKCNT_W = 3;
  localparam int ROWCNT_W  = 6;
  localparam int WCODE_W   = 3;
  localparam int ORDER_W   = 2;
  localparam int LOG_W     = 7;
  localparam int ROW_LIMIT = 31;

  typedef enum logic [WCODE_W-1:0] {
    WID_X8    = 3'd0,
    WID_X16   = 3'd1,
    WID_X32   = 3'd2,
    WID_X16E  = 3'd3,
    WID_X32E  = 3'd4
  } width_code_e;

  // Number of address bits that pick a byte inside one interface word.
  function automatic logic [1:0] lane_bits(input logic [WCODE_W-1:0] code);
    case (code)
      WID_X16, WID_X16E: lane_bits = 2'd1;
      WID_X32, WID_X32E: lane_bits = 2'd2;
      default:           lane_bits = 2'd0;
    endcase
  endfunction

  // Chip bit between bank and row for order codes 2 and 3.
  function automatic logic chip_in_middle(input logic [ORDER_W-1:0] code);
    chip_in_middle = (code == 2'd2) || (code == 2'd3);
  endfunction
endpackage

// File: rtl/dram_cap_calc.sv
module dram_cap_calc
  import dram_map_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DEFAULT_ROW = 14,
  localparam int CAP_W      = ADDR_W + 1
) (
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [COLCNT_W-1:0]  col_n_i,
  input  logic [BANKCNT_W-1:0] bank_n_i,
  input  logic [ROWCNT_W-1:0]  row_n_i,
  input  logic                 two_cs_i,
  input  logic [1:0]           lane_n_i,
  output logic [4:0]           row_eff_o,
  output logic [LOG_W-1:0]     log2_o,
  output logic [CAP_W-1:0]     cap_o,
  output logic                 oor_o
);
  logic [LOG_W-1:0] sum;

  always_comb begin
    if (row_n_i > ROWCNT_W'(ROW_LIMIT)) row_eff_o = 5'(DEFAULT_ROW);
    else                                row_eff_o = row_n_i[4:0];
  end

  always_comb begin
    sum = LOG_W'(col_n_i) + LOG_W'(bank_n_i) + LOG_W'(row_eff_o)
        + LOG_W'(lane_n_i) + LOG_W'(two_cs_i);
    log2_o = sum;
  end

  always_comb begin
    if (sum > LOG_W'(ADDR_W)) cap_o = '1;
    else                      cap_o = CAP_W'(1) << sum;
  end

  always_comb begin
    if (sum >= LOG_W'(ADDR_W)) oor_o = 1'b0;
    else                       oor_o = (addr_i >> sum) != '0;
  end
endmodule

// File: rtl/dram_field_slicer.sv
module dram_field_slicer
  import dram_map_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ROW_W  = 16,
  parameter int BANK_W = 3,
  parameter int COL_W  = 12
) (
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [COLCNT_W-1:0]  col_n_i,
  input  logic [BANKCNT_W-1:0] bank_n_i,
  input  logic [4:0]           row_n_i,
  input  logic                 two_cs_i,
  input  logic                 chip_mid_i,
  input  logic [1:0]           lane_n_i,
  output logic                 chip_o,
  output logic [ROW_W-1:0]     row_o,
  output logic [BANK_W-1:0]    bank_o,
  output logic [COL_W-1:0]     col_o
);
  function automatic logic [ADDR_W-1:0] low_mask(input int unsigned n);
    low_mask = ~({ADDR_W{1'b1}} << n);
  endfunction

  logic [ADDR_W-1:0] after_lane, after_col, after_bank, row_src;

  always_comb begin
    after_lane = addr_i >> lane_n_i;
    after_col  = after_lane >> col_n_i;
    after_bank = after_col >> bank_n_i;
    col_o      = COL_W'(after_lane & low_mask(32'(col_n_i)));
    bank_o     = BANK_W'(after_col & low_mask(32'(bank_n_i)));
    if (chip_mid_i) begin
      chip_o  = two_cs_i & after_bank[0];
      row_src = after_bank >> two_cs_i;
    end else begin
      row_src = after_bank;
      chip_o  = two_cs_i & (|((after_bank >> row_n_i) & ADDR_W'(1)));
    end
    row_o = ROW_W'(row_src & low_mask(32'(row_n_i)));
  end
endmodule

// File: rtl/dram_out_stage.sv
module dram_out_stage #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (REG_OUT) begin : g_reg
      logic [W-1:0] q_q, q_d;
      logic         seen_q;

      always_comb begin
        q_d = q_q;
        if (en_i) q_d = d_i;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
      end

      assign q_o = q_q;

      assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !$past(en_i)) |-> $stable(q_o));
      assert_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(en_i)) |-> (q_o == $past(d_i)));
    end else begin : g_comb
      assign q_o = d_i;
    end
  endgenerate
endmodule

// File: rtl/dram_addr_map.sv
module dram_addr_map
  import dram_map_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int ROW_W       = 16,
  parameter int BANK_W      = 3,
  parameter int COL_W       = 12,
  parameter int DEFAULT_ROW = 14,
  parameter bit REG_OUT     = 1'b1,
  localparam int CAP_W      = ADDR_W + 1,
  localparam int OUT_W      = 1 + ROW_W + BANK_W + COL_W + CAP_W + LOG_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [COLCNT_W-1:0]  cfg_col_bits_i,
  input  logic [BANKCNT_W-1:0] cfg_bank_bits_i,
  input  logic [ROWCNT_W-1:0]  cfg_row_bits_i,
  input  logic                 cfg_two_cs_i,
  input  logic [WCODE_W-1:0]   cfg_width_i,
  input  logic [ORDER_W-1:0]   cfg_order_i,
  output logic                 chip_o,
  output logic [ROW_W-1:0]     row_o,
  output logic [BANK_W-1:0]    bank_o,
  output logic [COL_W-1:0]     col_o,
  output logic [CAP_W-1:0]     cap_o,
  output logic [LOG_W-1:0]     cap_log2_o,
  output logic                 oor_o
);
  logic [1:0]        lane_n;
  logic              chip_mid;
  logic [4:0]        row_eff;
  logic [LOG_W-1:0]  log2_c;
  logic [CAP_W-1:0]  cap_c;
  logic              oor_c, chip_c;
  logic [ROW_W-1:0]  row_c;
  logic [BANK_W-1:0] bank_c;
  logic [COL_W-1:0]  col_c;
  logic [OUT_W-1:0]  pack_d, pack_q;

  assign lane_n   = lane_bits(cfg_width_i);
  assign chip_mid = chip_in_middle(cfg_order_i);

  dram_cap_calc #(.ADDR_W(ADDR_W), .DEFAULT_ROW(DEFAULT_ROW)) i_cap (
    .addr_i   (addr_i),
    .col_n_i  (cfg_col_bits_i),
    .bank_n_i (cfg_bank_bits_i),
    .row_n_i  (cfg_row_bits_i),
    .two_cs_i (cfg_two_cs_i),
    .lane_n_i (lane_n),
    .row_eff_o(row_eff),
    .log2_o   (log2_c),
    .cap_o    (cap_c),
    .oor_o    (oor_c)
  );

  dram_field_slicer #(.ADDR_W(ADDR_W), .ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W)) i_slice (
    .addr_i    (addr_i),
    .col_n_i   (cfg_col_bits_i),
    .bank_n_i  (cfg_bank_bits_i),
    .row_n_i   (row_eff),
    .two_cs_i  (cfg_two_cs_i),
    .chip_mid_i(chip_mid),
    .lane_n_i  (lane_n),
    .chip_o    (chip_c),
    .row_o     (row_c),
    .bank_o    (bank_c),
    .col_o     (col_c)
  );

  assign pack_d = {chip_c, row_c, bank_c, col_c, cap_c, log2_c, oor_c};

  dram_out_stage #(.W(OUT_W), .REG_OUT(REG_OUT)) i_out (
    .clk  (clk),
    .rst_n(rst_n),
    .en_i (en_i),
    .d_i  (pack_d),
    .q_o  (pack_q)
  );

  assign {chip_o, row_o, bank_o, col_o, cap_o, cap_log2_o, oor_o} = pack_q;

  // Chip field is silent with a single chip select (R4).
  assert_chip_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_two_cs_i |-> (chip_c == 1'b0));
  // Flag only possible when capacity is below the address space (R8).
  assert_oor_small_R8: assert property (@(posedge clk) disable iff (!rst_n)
    oor_c |-> (log2_c < LOG_W'(ADDR_W)));
  // Unsaturated capacity is a single power of two (R5).
  assert_cap_pow2_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (log2_c <= LOG_W'(ADDR_W)) |-> ($countones(cap_c) == 1));
  // Invalid row count keeps the row field within the default width (R7).
  assert_row_fallback_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_row_bits_i > ROWCNT_W'(ROW_LIMIT)) |-> ((32'(row_c) >> DEFAULT_ROW) == 0));
endmodule

// File: tb/test_dram_addr_map.sv
module test_dram_addr_map;
  localparam int ADDR_W = 32;
  localparam int ROW_W = 16, BANK_W = 3, COL_W = 12, DEF_ROW = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [3:0] ccol = '0;
  logic [2:0] cbank = '0;
  logic [5:0] crow = '0;
  logic ctwo = 1'b0;
  logic [2:0] cwid = '0;
  logic [1:0] cord = '0;
  logic chip;
  logic [ROW_W-1:0] row;
  logic [BANK_W-1:0] bank;
  logic [COL_W-1:0] col;
  logic [ADDR_W:0] cap;
  logic [6:0] clog;
  logic oor;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  dram_addr_map i_dram_addr_map (
    .clk(clk), .rst_n(rst_n), .en_i(en), .addr_i(addr),
    .cfg_col_bits_i(ccol), .cfg_bank_bits_i(cbank), .cfg_row_bits_i(crow),
    .cfg_two_cs_i(ctwo), .cfg_width_i(cwid), .cfg_order_i(cord),
    .chip_o(chip), .row_o(row), .bank_o(bank), .col_o(col),
    .cap_o(cap), .cap_log2_o(clog), .oor_o(oor));

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference model written from the requirements.
  task automatic expect_all(input string req);
    longint a, lg, e_cap, e_oor, e_chip, e_row, e_bank, e_col, r, lane;
    r = (crow > 31) ? DEF_ROW : crow;
    lane = (cwid == 1 || cwid == 3) ? 1 : (cwid == 2 || cwid == 4) ? 2 : 0;
    lg = ccol + cbank + r + lane + ctwo;
    e_cap = (lg > ADDR_W) ? ((64'd1 << (ADDR_W + 1)) - 1) : (64'd1 << lg);
    e_oor = (lg < ADDR_W && longint'(addr) >= e_cap) ? 1 : 0;
    a = longint'(addr) >> lane;
    e_col = a & ((64'd1 << ccol) - 1);
    a = a >> ccol;
    e_bank = a & ((64'd1 << cbank) - 1);
    a = a >> cbank;
    if (cord >= 2) begin
      e_chip = ctwo ? (a & 1) : 0;
      a = a >> ctwo;
      e_row = a & ((64'd1 << r) - 1);
    end else begin
      e_row = a & ((64'd1 << r) - 1);
      e_chip = ctwo ? ((a >> r) & 1) : 0;
    end
    chk(req, "col", longint'(col), e_col & ((64'd1 << COL_W) - 1));
    chk(req, "bank", longint'(bank), e_bank & ((64'd1 << BANK_W) - 1));
    chk(req, "row", longint'(row), e_row & ((64'd1 << ROW_W) - 1));
    chk(req, "chip", longint'(chip), e_chip);
    chk(req, "cap", longint'(cap), e_cap);
    chk(req, "log2", longint'(clog), lg);
    chk(req, "oor", longint'(oor), e_oor);
  endtask

  task automatic drive(input logic [31:0] a, input int c, input int b, input int r,
                       input bit two, input int w, input int o);
    @(negedge clk);
    addr = a; ccol = 4'(c); cbank = 3'(b); crow = 6'(r);
    ctwo = two; cwid = 3'(w); cord = 2'(o); en = 1'b1;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R10", "all outputs", longint'({chip, row, bank, col, cap, clog, oor}), 0);
  endtask

  task automatic t_orders;
    drive(32'h2ABC_DEF4, 10, 3, 14, 1'b1, 2, 0); expect_all("R2");
    drive(32'h2ABC_DEF4, 10, 3, 14, 1'b1, 2, 2); expect_all("R3");
    chk("R3", "chip mid bit", longint'(chip), longint'((32'h2ABC_DEF4 >> 15) & 1));
    drive(32'h2ABC_DEF4, 10, 3, 14, 1'b1, 2, 3); expect_all("R3");
    drive(32'h1357_9BDF, 9, 2, 13, 1'b1, 1, 1); expect_all("R2");
  endtask

  task automatic t_single_cs;
    drive(32'h0FFF_FFFF, 10, 3, 14, 1'b0, 2, 0); expect_all("R4");
    drive(32'h0FFF_FFFF, 10, 3, 14, 1'b0, 2, 2); expect_all("R4");
    chk("R4", "chip zero", longint'(chip), 0);
  endtask

  task automatic t_lanes;
    drive(32'h0000_0ABC, 8, 2, 12, 1'b0, 0, 0); expect_all("R1");
    drive(32'h0000_0ABC, 8, 2, 12, 1'b0, 1, 0); expect_all("R1");
    drive(32'h0000_0ABC, 8, 2, 12, 1'b0, 6, 0); expect_all("R1");
    chk("R1", "reserved width col", longint'(col), 64'hBC);
  endtask

  task automatic t_ecc;
    logic [ADDR_W:0] c32;
    drive(32'h0123_4567, 10, 3, 13, 1'b1, 2, 0); c32 = cap;
    drive(32'h0123_4567, 10, 3, 13, 1'b1, 4, 0); expect_all("R6");
    chk("R6", "ecc32 cap", longint'(cap), longint'(c32));
    drive(32'h0123_4567, 10, 3, 13, 1'b1, 3, 2); expect_all("R6");
    chk("R5", "cap formula", longint'(cap), 64'd1 << (10 + 3 + 13 + 1 + 1));
  endtask

  task automatic t_row_fallback;
    drive(32'h00FF_00FF, 9, 3, 40, 1'b1, 2, 0); expect_all("R7");
    chk("R7", "log2 default row", longint'(clog), 9 + 3 + DEF_ROW + 2 + 1);
    drive(32'h00FF_00FF, 9, 3, 63, 1'b0, 1, 2); expect_all("R7");
  endtask

  task automatic t_range;
    drive(32'h3FFF_FFFF, 10, 3, 14, 1'b1, 2, 0); expect_all("R8");
    chk("R8", "last byte in range", longint'(oor), 0);
    drive(32'h4000_0000, 10, 3, 14, 1'b1, 2, 0); expect_all("R8");
    chk("R8", "first byte out", longint'(oor), 1);
    drive(32'hFFFF_FFFF, 11, 3, 15, 1'b1, 2, 0); expect_all("R8");
    chk("R5", "cap 2^32", longint'(cap), 64'd1 << 32);
    drive(32'hFFFF_FFFF, 15, 7, 31, 1'b1, 2, 2); expect_all("R5");
    chk("R5", "saturated cap", longint'(cap), (64'd1 << 33) - 1);
  endtask

  task automatic t_hold;
    logic [ROW_W-1:0] r0; logic [COL_W-1:0] c0; logic o0;
    drive(32'h0000_1000, 10, 3, 14, 1'b1, 2, 0);
    r0 = row; c0 = col; o0 = oor;
    @(negedge clk);
    en = 1'b0; addr = 32'hFFFF_FFF8; crow = 6'd5;
    @(posedge clk); @(negedge clk); @(posedge clk); @(negedge clk);
    chk("R9", "hold row", longint'(row), longint'(r0));
    chk("R9", "hold col", longint'(col), longint'(c0));
    chk("R9", "hold oor", longint'(oor), longint'(o0));
    en = 1'b1;
    @(posedge clk); @(negedge clk);
    expect_all("R9");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_orders();
    t_single_cs();
    t_lanes();
    t_ecc();
    t_row_fallback();
    t_range();
    t_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule